// File: doc/BRIEF.md
# Four-to-Five Bit NRZI Line Encoder

This block takes two one-bit serial data lanes and turns them into a single self-clocking line bit stream. On every accepted transfer it takes one bit from each lane. Two consecutive transfers form a 4-bit nibble. Each nibble is translated into a 5-bit code word. The code words are shifted out one bit per clock, and the shifted bits are then NRZI coded onto the line. One nibble value is always sent as a framing word. That word cannot occur at any misaligned bit offset, so a receiver can find and keep code-word boundaries while data is flowing.

The input is a valid/ready port. A bit pair is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The sender has to keep `in_valid`, `in_a` and `in_b` steady until that happens. `in_ready` is computed only from internal state and never from `in_valid`. It goes low only while a nibble is waiting for the serializer and the next pair would complete another nibble. The line runs at a fixed pace of one code word every five clocks. When no complete nibble is waiting at a word boundary, an idle word is sent instead. This means the sender never has to keep up with the line.

Top module: `nrzi45_stream_encoder`

## Requirements
- R1: While `rst_n` is low, `line_o` is driven to 0 and `in_ready` is high. No nibble is held.
- R2: A nibble is built from two accepted pairs. The first pair supplies bits 3 (lane A) and 2 (lane B). The second pair supplies bits 1 (lane A) and 0 (lane B).
- R3: Nibble values other than the framing value map to these 5-bit words, MSB first: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R4: Every occurrence of the framing nibble (parameter `FRAME_NIBBLE`, default 4'hF) is sent as 10000, never as its table word.
- R5: When no complete nibble is pending at a word boundary, the idle word 11111 is sent. Idle words appear for as long as no data is pending.
- R6: The line toggles after a code bit of 1 and holds after a code bit of 0.
- R7: Word boundaries fall every five clocks, counted from the first clock edge after reset is released. The first word after reset is idle. Bits leave MSB first.
- R8: Every accepted nibble is sent exactly once, in the order of acceptance. A waiting nibble is never overwritten. `in_ready` is high whenever no nibble is waiting.
- R9: When input pairs are offered continuously, successive data words follow each other with no idle word between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A bit pair is offered on `in_a`/`in_b` |
| in_a | input | 1 | Lane A bit (upper bit of each pair) |
| in_b | input | 1 | Lane B bit (lower bit of each pair) |
| in_ready | output | 1 | The pair is taken at this edge if `in_valid` is high |
| line_o | output | 1 | NRZI coded line output |

## Verification
A code bit goes out at the edge that consumes it. The resulting line level can be seen at the next falling edge. The word loaded at edge 5k puts its bits on the line at edges 5k+1 through 5k+5. A nibble completed at some edge is loaded at the next boundary edge, which is the next multiple of five. The monitor samples `line_o` at every falling edge after reset is released. It recovers each code bit as the XOR of successive line levels and groups the bits into words on the fixed five-cycle grid. Each non-idle word is compared with the oldest entry the driver queued. Because the comparison is ordered rather than tied to a cycle, arbitrary input gaps do not break it. For the continuous-input case, the check is that the data words take strictly consecutive word slots.

// File: rtl/nrzi45_pkg.sv
package nrzi45_pkg;
  localparam int NIB_W   = 4;
  localparam int SYM_W   = 5;
  localparam int PAIRS   = NIB_W / 2;
  localparam int ACC_W   = NIB_W - 2;
  localparam int PAIR_CW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int SLOT_W  = $clog2(SYM_W);

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [SYM_W-1:0]  sym_t;
  typedef logic [SLOT_W-1:0] slot_t;

  localparam sym_t IDLE_SYM  = 5'b11111;
  // Four zeros in a row never arise from data/idle words (at most 3),
  // so this word only lines up on a true boundary.
  localparam sym_t FRAME_SYM = 5'b10000;

  function automatic sym_t data_code(nib_t n);
    sym_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/nrz45_pair_assembler.sv
module nrz45_pair_assembler
  import nrzi45_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_a,
  input  logic in_b,
  output logic in_ready,
  input  logic take,
  output logic hold_valid,
  output nib_t hold_nib
);
  localparam logic [PAIR_CW-1:0] LAST_PAIR = PAIR_CW'(PAIRS - 1);

  logic [PAIR_CW-1:0] pair_cnt;
  logic [ACC_W-1:0]   acc, acc_next;
  logic               accept, completes;

  generate
    if (ACC_W > 2) begin : g_wide
      assign acc_next = {acc[ACC_W-3:0], in_a, in_b};
    end else begin : g_narrow
      assign acc_next = {in_a, in_b};
    end
  endgenerate

  assign completes = (pair_cnt == LAST_PAIR);
  // A final pair needs a free holding slot, or one freed at this edge.
  assign in_ready  = !completes || !hold_valid || take;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_cnt   <= '0;
      acc        <= '0;
      hold_valid <= 1'b0;
      hold_nib   <= '0;
    end else begin
      if (take) hold_valid <= 1'b0;
      if (accept) begin
        if (completes) begin
          hold_nib   <= {acc, in_a, in_b};
          hold_valid <= 1'b1;
          pair_cnt   <= '0;
        end else begin
          acc      <= acc_next;
          pair_cnt <= pair_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nrz45_mapper.sv
module nrz45_mapper
  import nrzi45_pkg::*;
#(
  parameter nib_t FRAME_NIBBLE = 4'hF
)(
  input  logic hold_valid,
  input  nib_t hold_nib,
  output sym_t next_sym
);
  always_comb begin
    if (!hold_valid)                   next_sym = IDLE_SYM;
    else if (hold_nib == FRAME_NIBBLE) next_sym = FRAME_SYM;
    else                               next_sym = data_code(hold_nib);
  end
endmodule

// File: rtl/nrz45_serializer.sv
module nrz45_serializer
  import nrzi45_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  sym_t  next_sym,
  output logic  take,
  output logic  cur_bit,
  output slot_t slot,
  output sym_t  shreg,
  output logic  line_o
);
  localparam slot_t LAST_SLOT = SLOT_W'(SYM_W - 1);

  assign take    = (slot == LAST_SLOT);
  assign cur_bit = shreg[SYM_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= IDLE_SYM;
      slot   <= '0;
      line_o <= 1'b0;
    end else begin
      line_o <= line_o ^ cur_bit;
      if (take) begin
        shreg <= next_sym;
        slot  <= '0;
      end else begin
        shreg <= {shreg[SYM_W-2:0], 1'b0};
        slot  <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nrzi45_stream_encoder.sv
module nrzi45_stream_encoder
  import nrzi45_pkg::*;
#(
  parameter nib_t FRAME_NIBBLE = 4'hF
)(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_a,
  input  logic in_b,
  output logic in_ready,
  output logic line_o
);
  logic  take, hold_valid, cur_bit;
  nib_t  hold_nib;
  sym_t  next_sym, shreg;
  slot_t slot;

  nrz45_pair_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_ready(in_ready), .take(take), .hold_valid(hold_valid), .hold_nib(hold_nib)
  );

  nrz45_mapper #(.FRAME_NIBBLE(FRAME_NIBBLE)) u_map (
    .hold_valid(hold_valid), .hold_nib(hold_nib), .next_sym(next_sym)
  );

  nrz45_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .next_sym(next_sym), .take(take),
    .cur_bit(cur_bit), .slot(slot), .shreg(shreg), .line_o(line_o)
  );
endmodule

// File: rtl/nrzi45_stream_encoder_chk.sv
module nrzi45_stream_encoder_chk
  import nrzi45_pkg::*;
#(
  parameter nib_t FRAME_NIBBLE = 4'hF
)(
  input logic  clk,
  input logic  rst_n,
  input logic  in_ready,
  input logic  line_o,
  input logic  take,
  input logic  cur_bit,
  input slot_t slot,
  input sym_t  shreg,
  input logic  hold_valid,
  input nib_t  hold_nib
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (line_o == 1'b0 && in_ready && !hold_valid));

  // R6
  a_r6_nrzi_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((line_o ^ $past(line_o)) == $past(cur_bit)));

  // R7
  a_r7_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_W'(SYM_W - 1));

  // R5
  a_r5_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hold_valid) |=> (shreg == IDLE_SYM));

  // R4
  a_r4_frame_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hold_valid && hold_nib == FRAME_NIBBLE) |=> (shreg == FRAME_SYM));

  // R8
  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !take) |=> (hold_valid && $stable(hold_nib)));

  // R8
  a_r8_ready_free: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_valid |-> in_ready);
endmodule

bind nrzi45_stream_encoder nrzi45_stream_encoder_chk #(.FRAME_NIBBLE(FRAME_NIBBLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .line_o(line_o), .take(take),
  .cur_bit(cur_bit), .slot(slot), .shreg(shreg), .hold_valid(hold_valid),
  .hold_nib(hold_nib)
);

// File: tb/nrzi45_stream_encoder_test.sv
module nrzi45_stream_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] IDLE_W = 5'b11111;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_a = 1'b0, in_b = 1'b0;
  logic in_ready, line_o;

  int checks = 0, failures = 0;
  int idle_seen = 0;
  int last_data_idx = -10;
  bit saw_stall = 1'b0;
  logic [4:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nrzi45_stream_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_ready(in_ready), .line_o(line_o)
  );

  function automatic logic [4:0] ref_code(logic [3:0] n);
    logic [4:0] t [16];
    t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
          5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    if (n == 4'hF) return 5'b10000;
    return t[n];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic send_pair(logic a, logic b);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b;
    while (!in_ready) begin
      saw_stall = 1'b1;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic send_nib(logic [3:0] n, logic follow);
    expq.push_back({follow, n});
    send_pair(n[3], n[2]);
    send_pair(n[1], n[0]);
  endtask

  task automatic pause(int cyc);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  // Monitor: rebuild code bits from line levels, compare words in order.
  initial begin
    logic prev;
    logic [4:0] w;
    int nb, idx;
    prev = 1'b0; w = '0; nb = 0; idx = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      w = {w[3:0], line_o ^ prev};
      prev = line_o;
      nb++;
      if (nb == 5) begin
        nb = 0;
        if (idx == 0) begin
          check(w == IDLE_W, "R7", "first word after reset", w, IDLE_W);
        end else if (w == IDLE_W) begin
          idle_seen++;
        end else if (expq.size() == 0) begin
          check(1'b0, "R5", "data word with nothing pending", w, IDLE_W);
        end else begin
          logic [4:0] e;
          e = expq.pop_front();
          if (e[3:0] == 4'hF)
            check(w == ref_code(e[3:0]), "R4 R2", "framing word", w, ref_code(e[3:0]));
          else
            check(w == ref_code(e[3:0]), "R3 R2 R6", "data word", w, ref_code(e[3:0]));
          if (e[4])
            check(idx == last_data_idx + 1, "R9", "back-to-back slot", idx, last_data_idx + 1);
          last_data_idx = idx;
        end
        idx++;
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    check(1'b0, "R8", "watchdog timeout", 0, 1);
    report();
    $finish;
  end

  initial begin
    int idle_mark;
    logic l0;
    repeat (3) @(negedge clk);
    check(line_o == 1'b0, "R1", "line during reset", line_o, 0);
    check(in_ready == 1'b1, "R1", "ready during reset", in_ready, 1);
    rst_n = 1'b1;
    // Single nibbles with varied gaps, every value including framing.
    for (int v = 0; v < 16; v++) begin
      send_nib(4'(v), 1'b0);
      pause((v % 4) * 3);
    end
    send_nib(4'hF, 1'b0);
    send_nib(4'hF, 1'b0);
    pause(20);
    // Continuous burst: must fill consecutive word slots.
    send_nib(4'h5, 1'b0);
    for (int i = 1; i < 24; i++) send_nib(4'((i * 7) % 16), 1'b1);
    pause(1);
    idle_mark = idle_seen;
    repeat (60) @(negedge clk);
    check(expq.size() == 0, "R8", "nibbles left unsent", expq.size(), 0);
    check(saw_stall, "R8", "back-pressure seen in burst", saw_stall, 1);
    check(idle_seen - idle_mark >= 6, "R5", "idle words after drain", idle_seen - idle_mark, 6);
    l0 = line_o;
    @(negedge clk);
    check(line_o != l0, "R6", "line toggles during idle", line_o, !l0);
    report();
    $finish;
  end
endmodule